// File: doc/BRIEF.md
# Banked GPIO Controller with Set, Clear and Release Registers

This block controls a set of general-purpose pins through a small register bus made of an address, write data, a write strobe and a combinational read data path. Pins are grouped into banks of 32. Each bank has three write registers, and each acts only on the pins whose mask bits are one. The first drives its pins high. The second drives its pins low. The third hands its pins back to the pad as inputs. A pin becomes an output as soon as a level is written to it, so no separate direction write is needed. Reading the first register of a bank returns the pad levels after synchronization, whatever the direction of each pin.

The pads are modelled as three vectors: output values, output enables and sampled inputs. The synchronized input levels also drive one interrupt line per pin, and interrupt line i belongs to pin i. On the first clock after reset is released, the synchronized levels of the 64 lowest pins are copied into a snapshot that software can read as two words. The architecture allows for 128 pins and this instance implements 75 of them. Pin bits that are not implemented always read as zero, and writes to them are dropped.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, every pad output enable and every pad output value is 0.
- R2: A write to bank offset 0 (register index 0) sets both the output value and the output enable of every pin whose mask bit is 1.
- R3: A write to bank offset 1 clears the output value and sets the output enable of every pin whose mask bit is 1.
- R4: A write to bank offset 2 clears the output enable of every pin whose mask bit is 1 and keeps its output value.
- R5: Mask bits that are 0 leave the output value and output enable of their pins unchanged. When no write occurs, no pin changes.
- R6: Pin p sits in bank p/32 at bit p%32. The word address of bank b, offset r is b*4+r, where addr[7]=0 and addr[6:4]=0.
- R7: A read of bank offset 0 returns the pad levels after two synchronizer flops, regardless of direction. Offsets 1, 2 and 3 read as 0.
- R8: Pins 75 to 127 and the whole of bank 3 read as 0, and writes to them change no implemented pin.
- R9: On the first cycle after reset the synchronized levels of pins 0 to 63 are captured. Address 0x80 returns pins 0 to 31 and address 0x81 returns pins 32 to 63. The snapshot then stays fixed while pads change, and any other address with addr[7]=1 reads as 0.
- R10: irq_o[i] equals pad_in_i[i] delayed by two clock edges.
- R11: Writes to the snapshot region change neither the pins nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Word address |
| wr_data_i | input | 32 | Write mask |
| rd_data_o | output | 32 | Read data, combinational from the address |
| pad_in_i | input | 75 | Raw pad input levels |
| pad_out_o | output | 75 | Pad output values |
| pad_oe_o | output | 75 | Pad output enables |
| irq_o | output | 75 | Per-pin interrupt level |

## Verification
On every cycle, the assertions check the reset state of the pads, the effect on bank 0 of each of the three write types (including that unmasked pins are unchanged), the two-edge delay from pad to interrupt, and that the snapshot is loaded once and then holds. Several properties depend on the bench scenarios instead. These are the bank and bit mapping of the upper banks, the dropping of writes to pins that are not implemented and to bank 3, the zero reads of the unused offsets and the snapshot region, and the contents of the snapshot once the pads have changed. The behavioural model compares all of these on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register index inside a bank (address bits [1:0]); the read path decodes it too.
    typedef enum logic [1:0] {
        REG_LEVEL    = 2'd0,
        REG_DRIVE_LO = 2'd1,
        REG_RELEASE  = 2'd2,
        REG_SPARE    = 2'd3
    } bank_reg_e;

    localparam int REG_SEL_W = 2;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the pad inputs. It has no reset, so it keeps
// sampling while reset is asserted and is already filled when reset ends.
module gpio_sync #(
    parameter int WIDTH = 75
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/gpio_bank.sv
// Output state for the implemented pins of one bank.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  bank_reg_e       reg_sel_i,
    input  logic [PINS-1:0] mask_i,
    output logic [PINS-1:0] out_o,
    output logic [PINS-1:0] oe_o
);

    typedef struct packed {
        logic [PINS-1:0] out;
        logic [PINS-1:0] oe;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (reg_sel_i)
                REG_LEVEL: begin
                    st_d.out = st_q.out | mask_i;
                    st_d.oe  = st_q.oe | mask_i;
                end
                REG_DRIVE_LO: begin
                    st_d.out = st_q.out & ~mask_i;
                    st_d.oe  = st_q.oe | mask_i;
                end
                REG_RELEASE: begin
                    st_d.oe  = st_q.oe & ~mask_i;
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;
    assign oe_o  = st_q.oe;

endmodule

// File: rtl/gpio_snapshot.sv
// Loads the synchronized levels once, on the first clock after reset.
module gpio_snapshot #(
    parameter int WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] value_o
);

    typedef struct packed {
        logic             armed;
        logic [WIDTH-1:0] value;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.value = level_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.armed;
    assign value_o = st_q.value;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS  = 75,
    parameter int ARCH_PINS = 128,
    parameter int BANK_W    = 32,
    parameter int SNAP_PINS = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BANK_W-1:0]   wr_data_i,
    output logic [BANK_W-1:0]   rd_data_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] irq_o
);

    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int ARCH_BANKS = ARCH_PINS / BANK_W;
    localparam int BANK_SEL_W = $clog2(ARCH_BANKS);
    localparam int SNAP_WORDS = SNAP_PINS / BANK_W;
    localparam int SNAP_SEL_W = $clog2(SNAP_WORDS);
    localparam int BANK_TOP   = REG_SEL_W + BANK_SEL_W;

    // Address decode
    logic                  in_bank, in_snap;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic [SNAP_SEL_W-1:0] snap_word;
    bank_reg_e             reg_sel;

    assign in_bank   = !addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:BANK_TOP] == '0);
    assign in_snap   = addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:SNAP_SEL_W] == '0);
    assign bank_idx  = addr_i[BANK_TOP-1:REG_SEL_W];
    assign reg_sel   = bank_reg_e'(addr_i[REG_SEL_W-1:0]);
    assign snap_word = addr_i[SNAP_SEL_W-1:0];

    // Pad input synchronization
    logic [NUM_PINS-1:0] lvl_sync;

    gpio_sync #(
        .WIDTH (NUM_PINS)
    ) i_sync (
        .clk_i   (clk_i),
        .async_i (pad_in_i),
        .sync_o  (lvl_sync)
    );

    assign irq_o = lvl_sync;

    // Per-bank output state
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REM    = NUM_PINS - b * BANK_W;
        localparam int PINS_B = (REM < BANK_W) ? REM : BANK_W;
        logic bank_wr;

        assign bank_wr = wr_en_i && in_bank && (int'(bank_idx) == b);

        gpio_bank #(
            .PINS (PINS_B)
        ) i_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (bank_wr),
            .reg_sel_i (reg_sel),
            .mask_i    (wr_data_i[PINS_B-1:0]),
            .out_o     (pad_out_o[b*BANK_W +: PINS_B]),
            .oe_o      (pad_oe_o[b*BANK_W +: PINS_B])
        );
    end

    // Power-up level snapshot
    logic [SNAP_PINS-1:0] snap_lvl;
    logic [SNAP_PINS-1:0] snap_val;
    logic                 snap_valid;

    if (NUM_PINS >= SNAP_PINS) begin : g_snap_full
        assign snap_lvl = lvl_sync[SNAP_PINS-1:0];
    end else begin : g_snap_pad
        assign snap_lvl = {{(SNAP_PINS-NUM_PINS){1'b0}}, lvl_sync};
    end

    gpio_snapshot #(
        .WIDTH (SNAP_PINS)
    ) i_snap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (snap_lvl),
        .valid_o (snap_valid),
        .value_o (snap_val)
    );

    // Read path: levels padded out to the full architectural width
    logic [ARCH_PINS-1:0] lvl_arch;
    assign lvl_arch = {{(ARCH_PINS-NUM_PINS){1'b0}}, lvl_sync};

    always_comb begin
        rd_data_o = '0;
        if (in_bank) begin
            if (reg_sel == REG_LEVEL) begin
                rd_data_o = lvl_arch[int'(bank_idx)*BANK_W +: BANK_W];
            end
        end else if (in_snap) begin
            rd_data_o = snap_val[int'(snap_word)*BANK_W +: BANK_W];
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_PINS  = 75,
    parameter int SNAP_PINS = 64,
    parameter int ADDR_W    = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [31:0]          wr_data_i,
    input logic [NUM_PINS-1:0]  pad_in_i,
    input logic [NUM_PINS-1:0]  pad_out_o,
    input logic [NUM_PINS-1:0]  pad_oe_o,
    input logic [NUM_PINS-1:0]  irq_o,
    input logic                 snap_valid,
    input logic [SNAP_PINS-1:0] snap_val
);

    localparam logic [ADDR_W-1:0] A_LEVEL = 0;
    localparam logic [ADDR_W-1:0] A_LOW   = 1;
    localparam logic [ADDR_W-1:0] A_REL   = 2;

    p_reset_idle_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (pad_oe_o == '0 && pad_out_o == '0));

    p_set_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_LEVEL) |=>
        ((pad_out_o[31:0] & $past(wr_data_i)) == $past(wr_data_i)) &&
        ((pad_oe_o[31:0] & $past(wr_data_i)) == $past(wr_data_i)));

    p_drive_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_LOW) |=>
        ((pad_out_o[31:0] & $past(wr_data_i)) == '0) &&
        ((pad_oe_o[31:0] & $past(wr_data_i)) == $past(wr_data_i)));

    p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_REL) |=>
        ((pad_oe_o[31:0] & $past(wr_data_i)) == '0) &&
        ($stable(pad_out_o)));

    p_unmasked_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i <= A_REL) |=>
        ((pad_oe_o[31:0] & ~$past(wr_data_i)) == ($past(pad_oe_o[31:0]) & ~$past(wr_data_i))));

    p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

    p_irq_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(pad_in_i, 2));

    p_snap_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> snap_valid);

    p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(snap_valid) |-> $stable(snap_val));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NUM_PINS  (NUM_PINS),
    .SNAP_PINS (SNAP_PINS),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .irq_o      (irq_o),
    .snap_valid (snap_valid),
    .snap_val   (snap_val)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

    localparam int N = 75;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [31:0]   wdata = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  pad = {11'h5A3, 32'hDEAD_BEEF, 32'h1357_9BDF};
    logic [N-1:0]  pad_out, pad_oe, irq;

    always #4 clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rd_data),
        .pad_in_i  (pad),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .irq_o     (irq)
    );

    // Behavioural reference state
    bit [N-1:0] m_out = '0, m_oe = '0, m_s1 = '0, m_s2 = '0;
    bit [63:0]  m_snap = '0;
    bit         m_done = 1'b0;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic cmp(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rd(logic [7:0] a);
        bit [31:0] r = '0;
        if (a[7] == 1'b0 && a[6:4] == 3'b000) begin
            if (a[1:0] == 2'd0) begin
                for (int k = 0; k < 32; k++) begin
                    int idx = int'(a[3:2]) * 32 + k;
                    if (idx < N) r[k] = m_s2[idx];
                end
            end
        end else if (a[7] == 1'b1 && a[6:1] == 6'd0) begin
            r = a[0] ? m_snap[63:32] : m_snap[31:0];
        end
        return r;
    endfunction

    task automatic model_edge();
        bit [N-1:0] old_s2 = m_s2;
        m_s2 = m_s1;
        m_s1 = pad;
        if (!rst_n) begin
            m_out  = '0;
            m_oe   = '0;
            m_done = 1'b0;
            m_snap = '0;
        end else begin
            if (!m_done) begin
                m_snap = old_s2[63:0];
                m_done = 1'b1;
            end
            if (wr_en && addr[7] == 1'b0 && addr[6:4] == 3'b000) begin
                for (int k = 0; k < 32; k++) begin
                    int idx = int'(addr[3:2]) * 32 + k;
                    if (idx < N && wdata[k]) begin
                        case (addr[1:0])
                            2'd0: begin m_out[idx] = 1'b1; m_oe[idx] = 1'b1; end
                            2'd1: begin m_out[idx] = 1'b0; m_oe[idx] = 1'b1; end
                            2'd2: m_oe[idx] = 1'b0;
                            default: ;
                        endcase
                    end
                end
            end
        end
    endtask

    // One clock: drive inputs, advance the model at the edge, compare at the falling edge.
    task automatic step(string tag, bit chk, bit we, logic [7:0] a, logic [31:0] d);
        wr_en = we;
        addr  = a;
        wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (chk) begin
            cmp(tag, "pad_out", 128'(pad_out), 128'(m_out));
            cmp(tag, "pad_oe", 128'(pad_oe), 128'(m_oe));
            cmp(tag, "irq", 128'(irq), 128'(m_s2));
            cmp(tag, "rd_data", 128'(rd_data), 128'(exp_rd(a)));
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state (skip the first cycles while the synchronizer fills)
        step("R1", 1'b0, 1'b0, 8'h00, '0);
        step("R1", 1'b0, 1'b0, 8'h00, '0);
        step("R1", 1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF);
        step("R1", 1'b1, 1'b0, 8'h80, '0);
        rst_n = 1'b1;
        // R9: snapshot captured on first cycle out of reset
        step("R9", 1'b1, 1'b0, 8'h80, '0);
        step("R9", 1'b1, 1'b0, 8'h81, '0);
        step("R1", 1'b1, 1'b0, 8'h04, '0);
        // R2: drive high in bank 0
        step("R2", 1'b1, 1'b1, 8'h00, 32'hA5A5_0F0F);
        step("R5", 1'b1, 1'b1, 8'h00, 32'h0000_0000);
        step("R2", 1'b1, 1'b1, 8'h00, 32'h0000_F000);
        // R3: drive low in banks 0 and 1
        step("R3", 1'b1, 1'b1, 8'h01, 32'h0000_0F00);
        step("R3", 1'b1, 1'b1, 8'h05, 32'h8000_0001);
        step("R6", 1'b1, 1'b1, 8'h04, 32'h0F00_00F0);
        // R4: release to input
        step("R4", 1'b1, 1'b1, 8'h02, 32'hFFFF_0000);
        step("R4", 1'b1, 1'b1, 8'h06, 32'h0000_00FF);
        step("R5", 1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF);
        // R6 / R8: bank 2 only has 11 implemented pins
        step("R6", 1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF);
        step("R8", 1'b1, 1'b1, 8'h09, 32'hFFFF_F155);
        step("R8", 1'b1, 1'b0, 8'h08, '0);
        // R8: bank 3 writes and reads
        step("R8", 1'b1, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        step("R8", 1'b1, 1'b1, 8'h0D, 32'hFFFF_FFFF);
        step("R8", 1'b1, 1'b0, 8'h0C, '0);
        step("R8", 1'b1, 1'b1, 8'h03, 32'hFFFF_FFFF);
        // R7 / R10: new pad patterns, reads at every offset
        pad = {11'h7FF, 32'h0000_0000, 32'hFFFF_FFFF};
        step("R10", 1'b1, 1'b0, 8'h00, '0);
        step("R7", 1'b1, 1'b0, 8'h04, '0);
        step("R7", 1'b1, 1'b0, 8'h08, '0);
        pad = {11'h2AA, 32'hCAFE_F00D, 32'h0BAD_C0DE};
        step("R10", 1'b1, 1'b0, 8'h00, '0);
        step("R7", 1'b1, 1'b0, 8'h01, '0);
        step("R7", 1'b1, 1'b0, 8'h02, '0);
        step("R7", 1'b1, 1'b0, 8'h03, '0);
        step("R7", 1'b1, 1'b0, 8'h04, '0);
        step("R7", 1'b1, 1'b0, 8'h08, '0);
        for (int i = 0; i < 20; i++) begin
            pad = pad ^ (N'(1) << (i * 3));
            step("R10", 1'b1, 1'b0, 8'(i % 3) << 2, '0);
        end
        // R9: snapshot unchanged after pad changes; other snapshot addresses read 0
        step("R9", 1'b1, 1'b0, 8'h80, '0);
        step("R9", 1'b1, 1'b0, 8'h81, '0);
        step("R9", 1'b1, 1'b0, 8'h82, '0);
        step("R9", 1'b1, 1'b0, 8'hC0, '0);
        // R11: writes to the snapshot region do nothing
        step("R11", 1'b1, 1'b1, 8'h80, 32'hFFFF_FFFF);
        step("R11", 1'b1, 1'b1, 8'h81, 32'hFFFF_FFFF);
        step("R11", 1'b1, 1'b0, 8'h80, '0);
        step("R11", 1'b1, 1'b0, 8'h81, '0);
        // R6: address with unused middle bits set is not a bank
        step("R6", 1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF);
        step("R6", 1'b1, 1'b0, 8'h10, '0);
        // R1: re-entering reset clears outputs and re-arms the snapshot
        rst_n = 1'b0;
        step("R1", 1'b1, 1'b0, 8'h80, '0);
        rst_n = 1'b1;
        step("R9", 1'b1, 1'b0, 8'h80, '0);
        step("R9", 1'b1, 1'b0, 8'h81, '0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule